// File: doc/BRIEF.md
# Microsecond Timestamp and One-Shot Event Timer

This block supplies a system tick source to a processor subsystem. A fixed prescaler turns the peripheral clock into a 1 MHz tick. Two counters run on that tick. The first is a free-running 32-bit timestamp that counts up from reset and wraps. The second is a 32-bit countdown that software arms to raise an event after a chosen number of microseconds.

Software reaches the block through a byte-wide register port with separate read and write strobes. To reprogram the countdown, software takes three steps. It first writes the control byte with only the terminal-count bit set, which acknowledges any pending event and stops counting. It then writes the new count. Last, it writes the control byte with the terminal-count and enable bits set.

When the armed countdown expires, a sticky terminal-count flag is set, and the interrupt output follows that flag as a level until software clears it. In one-shot mode the counter stops at zero. In periodic mode it reloads the last value written and keeps running.

Top module: `evt_timer`

## Requirements
- R1: Both counters advance exactly once per TICK_DIV clock cycles. The default TICK_DIV of 400 turns a 400 MHz clock into 1 µs steps.
- R2: The timestamp is a 32-bit up-counter that runs whatever the control state and wraps at 2^32. It is read little-endian at byte offsets 0x08 to 0x0B. A read of 0x08 returns the live low byte and captures the whole value. Reads of 0x09 to 0x0B return bytes of that captured copy.
- R3: The countdown register sits little-endian at byte offsets 0x00 to 0x03. A read returns the current count. A byte write updates both the load value and the current count, but only while enable is 0. While enable is 1, a write to these offsets is ignored.
- R4: The control byte sits at offset 0x14. Bit 0 is enable, bit 1 is periodic mode, bit 2 is reload and bit 7 is the terminal-count flag. Writing reload as 1 copies the load value into the count. Reload and bits 3 to 6 read as 0.
- R5: In one-shot mode, a tick that finds the armed count at 1 or 0 sets the flag, clears enable and leaves the count at 0.
- R6: In periodic mode, expiry sets the flag, reloads the load value and leaves enable at 1.
- R7: Writing 1 to bit 7 of the control byte clears the flag. Writing 0 there leaves the flag unchanged. If an expiry and a clear land in the same cycle, the flag ends up set.
- R8: irq_o is a level equal to the terminal-count flag. It rises only in the cycle after a tick.
- R9: After reset, enable, periodic mode, the flag, the count, the load value, the timestamp, rdata_o and irq_o are all 0.
- R10: Offsets that map to nothing, including the holes and every offset from 0x16 upward, read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Byte offset of the access |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe; rdata_o is valid in the following cycle |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Registered read data byte |
| irq_o | output | 1 | Level interrupt, equal to the terminal-count flag |

## Verification
The bench builds the timer with TICK_DIV set to 4 and keeps the counters at 32 bits, so that a tick falls every fourth clock. At that rate, one-shot expiry and repeated periodic expiry fit in a few dozen cycles. The long-wait snapshot check can also watch the timestamp carry into its second byte. The exact-difference timestamp check depends on this small divider, because it spaces two reads by a whole number of tick periods.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W   = 5;
  localparam int OFS_CNT  = 'h00;
  localparam int OFS_TS   = 'h08;
  localparam int OFS_CTRL = 'h14;
  localparam int WIN_SIZE = 'h16;
  localparam int B_EN     = 0;
  localparam int B_PER    = 1;
  localparam int B_RLD    = 2;
  localparam int B_TC     = 7;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int TICK_DIV = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + PW'(1);
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/evt_stamp.sv
module evt_stamp #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] ts_o,
  output logic [CNT_W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ts_o <= '0;
    else if (tick_i) ts_o <= ts_o + CNT_W'(1);
  end

  // capture the live value so the upper bytes read coherently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_o <= '0;
    else if (snap_i) snap_o <= ts_o;
  end
endmodule

// File: rtl/evt_down.sv
module evt_down
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int NB   = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NB-1:0]    cnt_wr_i,
  input  logic             ctrl_wr_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             per_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] load_q;
  logic             expire;
  logic             ack;

  assign expire = tick_i && en_o && (cnt_o <= CNT_W'(1));
  assign ack    = ctrl_wr_i && wdata_i[B_TC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      load_q <= '0;
      en_o   <= 1'b0;
      per_o  <= 1'b0;
    end else begin
      if (expire) begin
        if (per_o) cnt_o <= load_q;
        else begin
          cnt_o <= '0;
          en_o  <= 1'b0;
        end
      end else if (tick_i && en_o) begin
        cnt_o <= cnt_o - CNT_W'(1);
      end
      // software control overrides the tick in the same cycle
      if (ctrl_wr_i) begin
        en_o  <= wdata_i[B_EN];
        per_o <= wdata_i[B_PER];
        if (wdata_i[B_RLD]) cnt_o <= load_q;
      end
      for (int b = 0; b < NB; b++) begin
        if (cnt_wr_i[b] && !en_o) begin
          load_q[8*b +: 8] <= wdata_i;
          cnt_o[8*b +: 8]  <= wdata_i;
        end
      end
    end
  end

  // a new expiry wins over a simultaneous acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (expire) flag_o <= 1'b1;
    else if (ack)    flag_o <= 1'b0;
  end
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int NB   = CNT_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  ts_i,
  input  logic [CNT_W-1:0]  snap_i,
  input  logic [7:0]        ctrl_i,
  output logic [NB-1:0]     cnt_wr_o,
  output logic              ctrl_wr_o,
  output logic              snap_o,
  output logic [7:0]        rdata_o
);
  logic [7:0] rd_mux;

  always_comb begin
    cnt_wr_o  = '0;
    ctrl_wr_o = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
    snap_o    = rd_i && (addr_i == ADDR_W'(OFS_TS));
    rd_mux    = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr_i == ADDR_W'(OFS_CNT + b)) begin
        cnt_wr_o[b] = wr_i;
        rd_mux      = cnt_i[8*b +: 8];
      end
      if (addr_i == ADDR_W'(OFS_TS + b))
        rd_mux = (b == 0) ? ts_i[7:0] : snap_i[8*b +: 8];
    end
    if (addr_i == ADDR_W'(OFS_CTRL)) rd_mux = ctrl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TICK_DIV = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int NB = CNT_W / 8;

  logic             tick;
  logic             snap_req;
  logic [CNT_W-1:0] ts_val;
  logic [CNT_W-1:0] ts_snap;
  logic [CNT_W-1:0] cnt_val;
  logic [NB-1:0]    cnt_wr;
  logic             ctrl_wr;
  logic             en;
  logic             per;
  logic             flag;
  logic [7:0]       ctrl_byte;

  always_comb begin
    ctrl_byte        = '0;
    ctrl_byte[B_EN]  = en;
    ctrl_byte[B_PER] = per;
    ctrl_byte[B_TC]  = flag;
  end

  evt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  evt_stamp #(.CNT_W(CNT_W)) u_stamp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .snap_i(snap_req),
    .ts_o  (ts_val),
    .snap_o(ts_snap)
  );

  evt_down #(.CNT_W(CNT_W)) u_down (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .cnt_wr_i (cnt_wr),
    .ctrl_wr_i(ctrl_wr),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt_val),
    .en_o     (en),
    .per_o    (per),
    .flag_o   (flag)
  );

  evt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .cnt_i    (cnt_val),
    .ts_i     (ts_val),
    .snap_i   (ts_snap),
    .ctrl_i   (ctrl_byte),
    .cnt_wr_o (cnt_wr),
    .ctrl_wr_o(ctrl_wr),
    .snap_o   (snap_req),
    .rdata_o  (rdata_o)
  );

  assign irq_o = flag;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [CNT_W-1:0]  ts_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              en_i,
  input logic              per_i,
  input logic              irq_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i
);
  localparam int NB = CNT_W / 8;

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  // R2
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (ts_i == $past(ts_i) + CNT_W'(1)));

  // R3
  cnt_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i < ADDR_W'(NB)) && en_i && !tick_i) |=> $stable(cnt_i));

  // R5
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_i) && !per_i && !$past(wr_i)) |-> (!en_i && cnt_i == '0));

  // R6
  periodic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_i) && per_i && !$past(wr_i)) |-> en_i);

  // R7
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(OFS_CTRL) && wdata_i[B_TC] && !tick_i) |=> !irq_i);

  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(tick_i));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick),
  .ts_i   (ts_val),
  .cnt_i  (cnt_val),
  .en_i   (en),
  .per_i  (per),
  .irq_i  (irq_o),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i)
);

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam int DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  evt_timer #(.CNT_W(32), .TICK_DIV(DIV)) uut (.*);

  typedef struct packed {
    logic       wr;
    logic [4:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h00, 8'h78},  // R3 load bytes
    '{1'b1, 5'h01, 8'h56},
    '{1'b1, 5'h02, 8'h34},
    '{1'b1, 5'h03, 8'h12},
    '{1'b0, 5'h00, 8'h78},  // R3 readback
    '{1'b0, 5'h03, 8'h12},
    '{1'b1, 5'h14, 8'h02},  // R4 periodic, disarmed
    '{1'b0, 5'h14, 8'h02},
    '{1'b1, 5'h18, 8'hff},  // R10 write outside window
    '{1'b0, 5'h16, 8'h00},  // R10
    '{1'b0, 5'h04, 8'h00},  // R10 hole
    '{1'b1, 5'h14, 8'h04},  // R4 reload reads back 0
    '{1'b0, 5'h14, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic load_cnt(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(5'(b), v[8*b +: 8]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v, v2, s1;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 irq", irq_o, 0);
    chk("R9 rdata", rdata_o, 0);
    rst_ni = 1'b1;
    rd(5'h14, v); chk("R9 ctrl", v, 8'h00);
    rd(5'h00, v); chk("R9 count", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        chk($sformatf("table entry %0d (R3/R4/R10)", i), v, VEC[i].data);
      end
    end
    rd(5'h01, v); chk("R10 no write effect", v, 8'h56);

    // R2 / R1 timestamp spacing of exactly 10 ticks
    rd(5'h08, v);
    repeat (38) @(negedge clk_i);
    rd(5'h08, v2);
    chk("R1 tick spacing", 8'(v2 - v), 8'd10);

    // R2 snapshot coherence
    rd(5'h08, v); rd(5'h09, s1);
    repeat (1100) @(negedge clk_i);
    rd(5'h09, v); chk("R2 snapshot held", v, s1);
    rd(5'h08, v); rd(5'h09, v);
    checks++;
    if (!(8'(v - s1) == 8'd1 || 8'(v - s1) == 8'd2)) begin
      errors++;
      $display("FAIL R2 snapshot advance: actual %0h expected %0h+1..2", v, s1);
    end

    // R5 one-shot
    wr(5'h14, 8'h80); load_cnt(32'd5); wr(5'h14, 8'h81);
    repeat (8) @(negedge clk_i);
    chk("R5 not yet expired", irq_o, 0);
    repeat (24) @(negedge clk_i);
    chk("R8 irq level", irq_o, 1);
    rd(5'h14, v); chk("R5 enable cleared", v, 8'h80);
    rd(5'h00, v); chk("R5 count held at 0", v, 8'h00);
    repeat (20) @(negedge clk_i);
    chk("R8 irq stays high", irq_o, 1);

    // R7 writing 0 to bit 7 leaves flag
    wr(5'h14, 8'h00);
    chk("R7 zero write ignored", irq_o, 1);
    wr(5'h14, 8'h80);
    chk("R7 W1C clears", irq_o, 0);

    // R6 periodic
    load_cnt(32'd3); wr(5'h14, 8'h83);
    for (int k = 0; k < 40 && !irq_o; k++) @(negedge clk_i);
    chk("R6 first expiry", irq_o, 1);
    wr(5'h14, 8'h83);
    chk("R7 ack keeps running", irq_o, 0);
    repeat (16) @(negedge clk_i);
    chk("R6 second expiry", irq_o, 1);
    rd(5'h14, v); chk("R6 still enabled", v, 8'h83);
    wr(5'h14, 8'h80);

    // R3 writes ignored while armed
    load_cnt(32'd100); wr(5'h14, 8'h01);
    wr(5'h01, 8'h77);
    rd(5'h01, v); chk("R3 armed write ignored", v, 8'h00);
    wr(5'h14, 8'h80);

    finish_run();
  end
endmodule